// File: doc/BRIEF.md
# Multi-Byte SPI Master

This block is a serial peripheral interface master that moves a burst of bytes to and from one slave, full duplex, under a single chip-select assertion. A host asserts `start` with a non-zero byte count. The block then pulls the selected active-low chip select down and clocks the bytes out on MOSI. For every byte sent, it shifts one byte in from MISO. Chip select is released only after the serial clock has returned to its idle level.

Several settings are chosen per burst and captured when the burst is accepted:
- which of the two chip-select lines to drive;
- bit order;
- whether the serial clock runs at one eighth or one sixteenth of the system clock;
- whether MISO is sampled on the rising or the falling SCLK edge;
- the level SCLK rests at between bursts.

MOSI always changes on the edge opposite the sampling edge. Transmit bytes are taken from `tx_data`, and every fetch is marked by a `tx_next` pulse. Received bytes appear on `rx_data` with an `rx_valid` strobe. `busy` covers the burst, and a one-cycle `done` marks its end.

Top module: `spi_burst_master`

## Requirements
- R1: The selected cs_n line goes low on the clock edge that accepts a start. It stays low without a break for the whole burst, and it rises only after SCLK has returned to its idle level.
- R2: For each of the num_bytes bytes sent, exactly one received byte is presented on rx_data with a one-cycle rx_valid strobe, in arrival order. A burst produces exactly num_bytes strobes.
- R3: cfg_cs_sel = 0 selects cs_n[0] and cfg_cs_sel = 1 selects cs_n[1]. The unselected line stays high, and at most one line is low at any time.
- R4: With cfg_div_fast = 1 the SCLK period is 8 system clocks; with 0 it is 16. Consecutive sampling edges in a burst are exactly one period apart, byte boundaries included.
- R5: With cfg_lsb_first = 0, bit 7 goes out first, so 0x05 appears on MOSI as 0,0,0,0,0,1,0,1. With cfg_lsb_first = 1, bit 0 goes out first. Received bytes are assembled in the same order as transmitted bytes.
- R6: With cfg_sample_fall = 0, MISO is sampled on rising SCLK edges and MOSI changes only on falling ones. With cfg_sample_fall = 1, the two edges swap roles.
- R7: While no burst runs, SCLK rests at cfg_idle_high (1 = high, 0 = low). Its value after reset is low.
- R8: With MISO held high for a whole burst, every received byte reads 0xFF.
- R9: Configuration inputs are captured when a start is accepted. Changing them while busy has no effect on the running burst. A start request made while busy is ignored.
- R10: busy is high from the accepting edge until the burst ends. done is a one-cycle pulse in the first cycle in which all cs_n are high and busy is low. After reset, all cs_n lines are high and busy and done are low.
- R11: A start with num_bytes = 0 is ignored: busy stays low and no chip select or tx_next activity follows.
- R12: tx_next pulses for one cycle each time a byte is taken from tx_data. The first pulse comes right after the accepting edge, and one more follows at each byte boundary, for exactly num_bytes pulses per burst. The host must present the next byte before the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request, taken when idle with a non-zero count |
| num_bytes | input | CNT_W | Number of bytes in the burst |
| cfg_cs_sel | input | SEL_W | Chip-select line to drive |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_div_fast | input | 1 | 1 = SCLK at clk/8, 0 = clk/16 |
| cfg_sample_fall | input | 1 | 1 = sample MISO on falling SCLK |
| cfg_idle_high | input | 1 | SCLK level between bursts |
| tx_data | input | DATA_W | Byte to transmit next |
| tx_next | output | 1 | Pulse: tx_data was taken |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | Pulse: rx_data holds a new byte |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The end of one burst and the acceptance of the next can fall in the same cycle. The cycle in which `done` pulses is already idle, so a `start` presented in that cycle must be taken. The bench provokes this by raising `start` at the falling clock edge where it first sees `done`. It then judges the second burst as it judges any other burst: one fresh chip-select fall, the right number of `tx_next` pulses, and every received and transmitted byte matched by the slave model and the scoreboard. It also checks that the chip select was high in the `done` cycle and that SCLK sat at its idle level when the select rose.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_FIRST,
      ST_SECOND,
      ST_TRAIL
   } burst_state_t;

   typedef struct packed {
      logic lsb_first;
      logic div_fast;
      logic sample_fall;
      logic idle_high;
   } link_cfg_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
   parameter int SLOW_DIV = 16,
   parameter int FAST_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic tick
);
   localparam int SLOW_HALF = SLOW_DIV / 2;
   localparam int FAST_HALF = FAST_DIV / 2;
   localparam int CNT_W     = $clog2(SLOW_HALF);

   generate
      if (FAST_DIV < 4 || (FAST_DIV % 2) != 0 || (SLOW_DIV % 2) != 0 || FAST_DIV > SLOW_DIV) begin : g_bad_div
         $error("spi_half_timer: dividers must be even, at least 4, and FAST_DIV <= SLOW_DIV");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = fast ? CNT_W'(FAST_HALF - 1) : CNT_W'(SLOW_HALF - 1);
   assign tick  = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R4: the half-period counter never passes its limit while running
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= limit));

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_byte,
   input  logic              lsb_first,
   input  logic              advance,
   input  logic              sample,
   input  logic              miso,
   output logic              mosi_bit,
   output logic              last_bit,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_strobe
);
   localparam int IDX_W = $clog2(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_shift_unit: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] tx_q, rx_q, rx_next, rx_out_q;
   logic [IDX_W-1:0]  idx_q;
   logic              strobe_q;

   assign mosi_bit  = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
   assign rx_next   = lsb_first ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
   assign last_bit  = (idx_q == IDX_W'(DATA_W - 1));
   assign rx_byte   = rx_out_q;
   assign rx_strobe = strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q     <= '0;
         rx_q     <= '0;
         rx_out_q <= '0;
         idx_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         if (load) begin
            tx_q  <= load_byte;
            idx_q <= '0;
         end else if (advance) begin
            tx_q  <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
            idx_q <= idx_q + IDX_W'(1);
         end
         if (sample) begin
            rx_q <= rx_next;
            if (last_bit) begin
               rx_out_q <= rx_next;
               strobe_q <= 1'b1;
            end
         end
      end
   end

   // R6: sampling never coincides with a data change on MOSI
   p_sample_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample |-> !(advance || load));

   // R2: one strobe per completed byte, never two in a row
   p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
   import spi_burst_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 8,
   parameter int NUM_CS   = 2,
   parameter int SLOW_DIV = 16,
   parameter int FAST_DIV = 8,
   localparam int SEL_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  num_bytes,
   input  logic [SEL_W-1:0]  cfg_cs_sel,
   input  logic              cfg_lsb_first,
   input  logic              cfg_div_fast,
   input  logic              cfg_sample_fall,
   input  logic              cfg_idle_high,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_next,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n
);

   generate
      if (NUM_CS < 1 || CNT_W < 1) begin : g_bad_cfg
         $error("spi_burst_master: NUM_CS and CNT_W must be at least 1");
      end
   endgenerate

   burst_state_t      state_q;
   link_cfg_t         cfg_q;
   logic [CNT_W-1:0]  left_q;
   logic              sclk_q, done_q, tx_next_q;
   logic [NUM_CS-1:0] cs_n_q, sel_hot;

   logic tick, accept, lead_lvl, load, advance, sample, mosi_bit, last_bit;

   // one-hot decode of the requested chip select
   genvar g;
   generate
      for (g = 0; g < NUM_CS; g++) begin : g_sel
         assign sel_hot[g] = (int'(cfg_cs_sel) == g);
      end
   endgenerate

   assign accept   = (state_q == ST_IDLE) && start && (num_bytes != '0) && (int'(cfg_cs_sel) < NUM_CS);
   assign lead_lvl = cfg_q.sample_fall;
   assign sample   = (state_q == ST_FIRST) && tick;
   assign advance  = (state_q == ST_SECOND) && tick && !last_bit;
   assign load     = accept || ((state_q == ST_SECOND) && tick && last_bit && (left_q != CNT_W'(1)));

   spi_half_timer #(
      .SLOW_DIV (SLOW_DIV),
      .FAST_DIV (FAST_DIV)
   ) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q != ST_IDLE),
      .fast  (cfg_q.div_fast),
      .tick  (tick)
   );

   spi_shift_unit #(
      .DATA_W (DATA_W)
   ) shifter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_byte (tx_data),
      .lsb_first (cfg_q.lsb_first),
      .advance   (advance),
      .sample    (sample),
      .miso      (miso),
      .mosi_bit  (mosi_bit),
      .last_bit  (last_bit),
      .rx_byte   (rx_data),
      .rx_strobe (rx_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cfg_q     <= '0;
         left_q    <= '0;
         sclk_q    <= 1'b0;
         cs_n_q    <= '1;
         done_q    <= 1'b0;
         tx_next_q <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         tx_next_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               sclk_q <= cfg_idle_high;
               if (accept) begin
                  cfg_q     <= '{lsb_first: cfg_lsb_first, div_fast: cfg_div_fast,
                                 sample_fall: cfg_sample_fall, idle_high: cfg_idle_high};
                  left_q    <= num_bytes;
                  cs_n_q    <= ~sel_hot;
                  tx_next_q <= 1'b1;
                  state_q   <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  sclk_q  <= lead_lvl;
                  state_q <= ST_FIRST;
               end
            end
            ST_FIRST: begin
               if (tick) begin
                  sclk_q  <= ~lead_lvl;
                  state_q <= ST_SECOND;
               end
            end
            ST_SECOND: begin
               if (tick) begin
                  if (last_bit && (left_q == CNT_W'(1))) begin
                     sclk_q  <= cfg_q.idle_high;
                     state_q <= ST_TRAIL;
                  end else begin
                     sclk_q  <= lead_lvl;
                     state_q <= ST_FIRST;
                     if (last_bit) begin
                        left_q    <= left_q - CNT_W'(1);
                        tx_next_q <= 1'b1;
                     end
                  end
               end
            end
            ST_TRAIL: begin
               if (tick) begin
                  cs_n_q  <= '1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign tx_next = tx_next_q;
   assign sclk    = sclk_q;
   assign cs_n    = cs_n_q;
   assign mosi    = (state_q != ST_IDLE) ? mosi_bit : 1'b0;

   // R3: never more than one select low
   p_single_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n_q) <= 1);

   // R1: the select stays put through the whole burst
   p_cs_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cs_n_q));

   // R9: captured settings cannot move while a burst runs
   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_q));

   // R10: done only while idle with every select released
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((state_q == ST_IDLE) && (&cs_n_q)));

   // R10: done lasts one cycle
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
   localparam int DW  = 8;
   localparam int CW  = 8;
   localparam int NCS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          start = 1'b0;
   logic [CW-1:0] num_bytes = '0;
   logic          cs_sel = 1'b0;
   logic          cfg_lsb = 1'b0, cfg_fast = 1'b0, cfg_fall = 1'b0, cfg_idle = 1'b0;
   logic [DW-1:0] tx_data, rx_data;
   logic          tx_next, rx_valid, busy, done, sclk, mosi;
   logic          miso = 1'b1;
   logic [NCS-1:0] cs_n;

   logic [7:0] txbuf [16];
   logic [7:0] slvbuf [16];
   int tx_idx = 0;
   assign tx_data = txbuf[tx_idx & 15];

   spi_burst_master dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .num_bytes (num_bytes),
      .cfg_cs_sel (cs_sel), .cfg_lsb_first (cfg_lsb), .cfg_div_fast (cfg_fast),
      .cfg_sample_fall (cfg_fall), .cfg_idle_high (cfg_idle), .tx_data (tx_data),
      .tx_next (tx_next), .rx_data (rx_data), .rx_valid (rx_valid), .busy (busy),
      .done (done), .sclk (sclk), .mosi (mosi), .miso (miso), .cs_n (cs_n)
   );

   int checks = 0;
   int fails  = 0;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // burst context as the bench expects it
   bit b_sel, b_lsb, b_fast, b_fall, b_idle, b_absent;
   logic [7:0] exp_rx_q [$];
   logic [7:0] exp_mosi_q [$];
   int cs_falls, tx_next_cnt, err_period, err_other_cs, err_cs_rise, cyc;
   logic prev_sclk = 1'b0, prev_cs = 1'b1;
   int s_pos, s_byte, s_bits, last_samp;
   bit s_sampled;
   logic [7:0] s_in;

   function automatic logic slave_bit();
      if (b_absent) return 1'b1;
      return b_lsb ? slvbuf[s_byte & 15][s_pos] : slvbuf[s_byte & 15][7 - s_pos];
   endfunction

   // monitor and slave model, evaluated away from the active edge
   always @(negedge clk) begin : mon
      logic cur_cs;
      logic [7:0] e;
      cyc++;
      if (rst_n) begin
         cur_cs = cs_n[b_sel];
         if (cs_n[!b_sel] == 1'b0) err_other_cs++;
         if (tx_next) begin
            tx_next_cnt++;
            tx_idx++;
         end
         if (rx_valid) begin
            if (exp_rx_q.size() == 0) check(1'b0, "R2", "unexpected received byte", rx_data, 0);
            else begin
               e = exp_rx_q.pop_front();
               check(rx_data == e, b_absent ? "R8" : "R2", "received byte", rx_data, e);
            end
         end
         if (prev_cs && !cur_cs) begin
            cs_falls++;
            s_pos = 0; s_byte = 0; s_bits = 0; s_sampled = 0; last_samp = -1;
            miso = slave_bit();
         end
         if (!prev_cs && cur_cs && (sclk !== b_idle)) err_cs_rise++;
         if (!cur_cs && (sclk !== prev_sclk)) begin
            if (sclk === ~b_fall) begin
               s_in = b_lsb ? {mosi, s_in[7:1]} : {s_in[6:0], mosi};
               if (last_samp >= 0 && (cyc - last_samp) != (b_fast ? 8 : 16)) err_period++;
               last_samp = cyc;
               s_sampled = 1;
               s_bits++;
               if (s_bits == 8) begin
                  s_bits = 0;
                  if (exp_mosi_q.size() == 0) check(1'b0, "R5", "unexpected MOSI byte", s_in, 0);
                  else begin
                     e = exp_mosi_q.pop_front();
                     check(s_in == e, "R5 R6", "byte seen on MOSI", s_in, e);
                  end
               end
            end else if (s_sampled) begin
               s_sampled = 0;
               s_pos++;
               if (s_pos == 8) begin
                  s_pos = 0;
                  s_byte++;
               end
               miso = slave_bit();
            end
         end
         prev_cs   = cur_cs;
         prev_sclk = sclk;
      end
   end

   task automatic run_burst(input bit sel, input bit lsb, input bit fast, input bit fall, input bit idle,
                            input int n, input bit absent, input bit disturb, input bit chain,
                            input logic [7:0] tbase, input logic [7:0] sbase);
      int nb;
      bit got;
      nb = chain ? 2 : 1;
      b_sel = sel; b_lsb = lsb; b_fast = fast; b_fall = fall; b_idle = idle; b_absent = absent;
      for (int i = 0; i < n; i++) begin
         txbuf[i]  = tbase + 8'(i);
         slvbuf[i] = sbase + 8'(i);
      end
      for (int k = 0; k < nb; k++) begin
         for (int i = 0; i < n; i++) begin
            exp_mosi_q.push_back(txbuf[i]);
            exp_rx_q.push_back(absent ? 8'hFF : slvbuf[i]);
         end
      end
      cs_falls = 0; tx_next_cnt = 0; err_period = 0; err_other_cs = 0; err_cs_rise = 0;
      @(negedge clk);
      cs_sel = sel; cfg_lsb = lsb; cfg_fast = fast; cfg_fall = fall; cfg_idle = idle;
      num_bytes = CW'(n);
      @(negedge clk);
      check(sclk == idle, "R7", "idle SCLK level before burst", sclk, idle);
      tx_idx = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R10", "busy after accept", busy, 1);
      check(cs_n[sel] == 1'b0, "R1", "selected cs low after accept", cs_n[sel], 0);
      if (disturb) begin
         repeat (10) @(negedge clk);
         cs_sel = ~sel; cfg_lsb = ~lsb; cfg_fast = ~fast; cfg_fall = ~fall; cfg_idle = ~idle;
         num_bytes = CW'(1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         check(busy == 1'b1, "R9", "busy kept through ignored start", busy, 1);
         repeat (20) @(negedge clk);
         cs_sel = sel; cfg_lsb = lsb; cfg_fast = fast; cfg_fall = fall; cfg_idle = idle;
      end
      for (int k = 0; k < nb; k++) begin
         got = 0;
         for (int w = 0; w < 40000 && !got; w++) begin
            @(negedge clk);
            if (done) got = 1;
         end
         check(got, "R10", "done seen", got, 1);
         check(&cs_n, "R10", "all cs high at done", cs_n, 3);
         check(busy == 1'b0, "R10", "busy low at done", busy, 0);
         check(sclk == idle, "R7", "SCLK idle after burst", sclk, idle);
         if (chain && k == 0) begin
            tx_idx = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(done == 1'b0, "R10", "done one cycle", done, 0);
            check(cs_n[sel] == 1'b0, "R1", "restart in done cycle lowers cs", cs_n[sel], 0);
         end else begin
            @(negedge clk);
            check(done == 1'b0, "R10", "done one cycle", done, 0);
         end
      end
      check(exp_rx_q.size() == 0, "R2", "received bytes outstanding", exp_rx_q.size(), 0);
      check(exp_mosi_q.size() == 0, "R5", "MOSI bytes outstanding", exp_mosi_q.size(), 0);
      check(cs_falls == nb, "R1", "cs falls per burst", cs_falls, nb);
      check(tx_next_cnt == n * nb, "R12", "tx_next pulses", tx_next_cnt, n * nb);
      check(err_period == 0, "R4", "SCLK period errors", err_period, 0);
      check(err_other_cs == 0, "R3", "unselected cs low", err_other_cs, 0);
      check(err_cs_rise == 0, "R1", "cs rose with SCLK not idle", err_cs_rise, 0);
      exp_rx_q.delete();
      exp_mosi_q.delete();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(&cs_n, "R10", "reset cs_n", cs_n, 3);
      check(busy == 1'b0, "R10", "reset busy", busy, 0);
      check(done == 1'b0, "R10", "reset done", done, 0);
      check(sclk == 1'b0, "R7", "reset SCLK low", sclk, 0);
      check(rx_valid == 1'b0, "R2", "reset rx_valid", rx_valid, 0);

      // R2 R5 R6: eight bytes, msb first, rising sample, clk/16, cs0
      run_burst(0, 0, 0, 0, 0, 8, 0, 0, 0, 8'h00, 8'h6f);
      // R3 R4 R5 R6 R7: cs1, lsb first, clk/8, falling sample, idle high
      run_burst(1, 1, 1, 1, 1, 4, 0, 0, 0, 8'h05, 8'h17);
      // R6 R7: idle high with rising sample
      run_burst(0, 0, 1, 0, 1, 3, 0, 0, 0, 8'h3c, 8'h80);
      // R6: idle low with falling sample, lsb first
      run_burst(1, 1, 0, 1, 0, 2, 0, 0, 0, 8'hc3, 8'h5a);
      // R5: single 0x05 msb first
      run_burst(0, 0, 0, 0, 0, 1, 0, 0, 0, 8'h05, 8'ha0);
      // R8: no slave, MISO stuck high
      run_burst(1, 0, 1, 0, 0, 8, 1, 0, 0, 8'h10, 8'h00);
      // R9: settings and start disturbed while busy
      run_burst(0, 0, 1, 0, 0, 3, 0, 1, 0, 8'h71, 8'h22);

      // R11: zero count start ignored
      @(negedge clk);
      num_bytes = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b0, "R11", "busy after zero-count start", busy, 0);
      check(&cs_n, "R11", "cs after zero-count start", cs_n, 3);
      check(tx_next == 1'b0, "R11", "tx_next after zero-count start", tx_next, 0);

      // R1 R10 R12: start taken in the done cycle
      run_burst(0, 1, 1, 0, 0, 3, 0, 0, 1, 8'h90, 8'h44);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule